// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial front-end of a byte-addressed non-volatile memory model. The front-end decodes the command and address fields. It then hands this block a strobe that opens an array write, together with the start address, and one strobe per completed data byte. The block gathers the bytes into a page buffer of 16 entries. The column pointer starts at the low address bits and wraps inside the page, so a long burst keeps only the last 16 bytes received. A byte-valid mask records which columns were sent.

When chip select rises, the block decides whether to run a write cycle. It needs a page write that is open, at least one byte in the buffer, a partial-bit count of zero, and write enable set. If all hold, it raises busy for a fixed number of system clocks. During the first 16 of those clocks it walks the page in ascending column order. It drives a write to the array for each column that was received and that lies outside the protected range. In the last busy clock it pulses a request that tells the status logic to clear write enable. The same timer also paces status-register writes: it pulses a commit strobe for the status logic in the final busy clock and issues no array write.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, busy, memWe, wenClr and srCommit are all 0.
- R2: Byte k (counting from 0) of a page write goes to address {startAddr[ADDR_W-1:4], (startAddr[3:0]+k) mod 16}. The column wraps from 15 to 0 and never leaves the start page.
- R3: When more than 16 bytes are sent, each column holds the last byte sent to it, and each column is written to the array at most once per cycle.
- R4: Columns of the page that received no byte are not written, and the array keeps their old contents.
- R5: A cycle starts only if tailBits is 0 in the csRise cycle. Any other value discards the attempt: busy stays 0 and the array is unchanged.
- R6: With wen at 0 in the csRise cycle, nothing starts and the array is unchanged. An open page write that received no data byte also starts nothing.
- R7: protLevel selects the write-protected addresses: 0 none, 1 the top quarter (top two address bits 11), 2 the top half (top bit 1), 3 the whole array. Protected bytes are never written, while the cycle still runs.
- R8: busy rises at the clock edge that samples csRise and stays high for exactly WR_CYCLES clocks. All memWe pulses fall within the first 16 busy clocks, one column per clock in ascending column order.
- R9: wenClr is a single-clock pulse in the last busy clock. busy falls on the next edge.
- R10: A status write (srByte, then csRise with tailBits 0, wen 1 and srLocked 0) holds busy for WR_CYCLES clocks with no memWe, and pulses srCommit together with wenClr. With srLocked at 1, nothing starts.
- R11: While busy is high, including its final clock, wrStart, dataByte, srByte and csRise have no effect. They neither disturb the commit in progress nor open a write afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStart | input | 1 | Page write opened, address field complete |
| startAddr | input | ADDR_W | Start byte address of the page write |
| dataByte | input | 1 | One data byte complete |
| dataIn | input | 8 | Data byte value |
| srByte | input | 1 | Status-register data byte complete |
| tailBits | input | 3 | Bits received past the last full byte |
| csRise | input | 1 | Chip select has risen (end of transaction) |
| wen | input | 1 | Write enable from the status logic |
| srLocked | input | 1 | Status register hardware-locked |
| protLevel | input | 2 | Block protection level |
| busy | output | 1 | Write cycle in progress |
| wenClr | output | 1 | Request to clear write enable |
| srCommit | output | 1 | Status value may be committed now |
| memWe | output | 1 | Array write strobe |
| memAddr | output | ADDR_W | Array write address |
| memWdata | output | 8 | Array write data |

## Verification
Two things can land in the same clock: the final busy clock, where wenClr pulses, and the opening of a new instruction by the front-end. The bench raises wrStart exactly in the clock where it sees wenClr. After busy drops it sends data bytes and a clean csRise. It passes only if no second cycle starts and the array image still matches its own model. A second overlap puts a wrStart to another page in the middle of a commit. The page that was buffered must still land intact, which the bench checks by comparing the whole array.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  localparam int PAGE_COL_W = 4;
  localparam int PAGE_BYTES = 1 << PAGE_COL_W;

  typedef enum logic [1:0] {
    CK_IDLE = 2'd0,
    CK_PAGE = 2'd1,
    CK_STAT = 2'd2
  } cycKind_e;

  typedef struct packed {
    logic                  clear;
    logic                  load;
    logic                  commit;
    logic [PAGE_COL_W-1:0] slot;
  } bufStrobe_t;

endpackage

// File: rtl/pgwr_guard.sv
module pgwr_guard #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        protLevel,
  output logic              hit
);

  logic topQuarter;
  logic topHalf;

  always_comb begin
    topHalf    = addr[ADDR_W-1];
    topQuarter = addr[ADDR_W-1] & addr[ADDR_W-2];
    unique case (protLevel)
      2'd0:    hit = 1'b0;
      2'd1:    hit = topQuarter;
      2'd2:    hit = topHalf;
      default: hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int WR_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStart,
  input  logic       dataByte,
  input  logic       srByte,
  input  logic [2:0] tailBits,
  input  logic       csRise,
  input  logic       wen,
  input  logic       srLocked,
  input  logic       anyByte,
  output bufStrobe_t strb,
  output logic       busy,
  output logic       wenClr,
  output logic       srCommit
);

  localparam int CW = $clog2(WR_CYCLES);
  localparam logic [CW-1:0] LAST_CNT = CW'(WR_CYCLES - 1);
  localparam logic [CW-1:0] SWEEP_END = CW'(PAGE_BYTES);

  cycKind_e        state;
  logic [CW-1:0]   cnt;
  logic            armPage;
  logic            armStat;
  logic            idle;
  logic            aligned;
  logic            goPage;
  logic            goStat;
  logic            lastCyc;

  always_comb begin
    idle    = (state == CK_IDLE);
    aligned = (tailBits == 3'd0);
    goPage  = idle & csRise & aligned & wen & armPage & anyByte;
    goStat  = idle & csRise & aligned & wen & ~srLocked & armStat & ~goPage;
    lastCyc = ~idle & (cnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CK_IDLE;
      cnt     <= '0;
      armPage <= 1'b0;
      armStat <= 1'b0;
    end else if (idle) begin
      if (csRise) begin
        armPage <= 1'b0;
        armStat <= 1'b0;
        cnt     <= '0;
        if (goPage)      state <= CK_PAGE;
        else if (goStat) state <= CK_STAT;
      end else if (wrStart) begin
        armPage <= 1'b1;
        armStat <= 1'b0;
      end else if (srByte) begin
        armStat <= 1'b1;
        armPage <= 1'b0;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (lastCyc) state <= CK_IDLE;
    end
  end

  always_comb begin
    strb.clear  = idle & wrStart & ~csRise;
    strb.load   = idle & armPage & dataByte & ~csRise & ~wrStart;
    strb.commit = (state == CK_PAGE) && (cnt < SWEEP_END);
    strb.slot   = cnt[PAGE_COL_W-1:0];
    busy        = ~idle;
    wenClr      = lastCyc;
    srCommit    = lastCyc & (state == CK_STAT);
  end

  AST_START_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wen)) else $error("busy rose without wen"); // R6

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(tailBits) == 3'd0)) else $error("busy rose on partial byte"); // R5

  AST_END_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(wenClr)) else $error("busy fell without wenClr"); // R9

  AST_CLEAR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wenClr |=> !busy) else $error("busy held after wenClr"); // R9

  AST_SR_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    srCommit |-> wenClr) else $error("srCommit outside final clock"); // R10

endmodule

// File: rtl/pgwr_dpath.sv
module pgwr_dpath
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        dataIn,
  input  logic [1:0]        protLevel,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              anyByte
);

  localparam int PAGE_W = ADDR_W - PAGE_COL_W;

  logic [PAGE_W-1:0]     pageBase;
  logic [PAGE_COL_W-1:0] col;
  logic [7:0]            lane     [PAGE_BYTES];
  logic                  laneSeen [PAGE_BYTES];
  logic                  protHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      col      <= '0;
    end else if (strb.clear) begin
      pageBase <= startAddr[ADDR_W-1:PAGE_COL_W];
      col      <= startAddr[PAGE_COL_W-1:0];
    end else if (strb.load) begin
      col <= col + 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lane[i]     <= '0;
        laneSeen[i] <= 1'b0;
      end else if (strb.clear) begin
        laneSeen[i] <= 1'b0;
      end else if (strb.load && (col == PAGE_COL_W'(i))) begin
        lane[i]     <= dataIn;
        laneSeen[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    anyByte = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) anyByte = anyByte | laneSeen[i];
  end

  pgwr_guard #(.ADDR_W(ADDR_W)) u_guard (
    .addr      (memAddr),
    .protLevel (protLevel),
    .hit       (protHit)
  );

  always_comb begin
    memAddr  = {pageBase, strb.slot};
    memWdata = lane[strb.slot];
    memWe    = strb.commit & laneSeen[strb.slot] & ~protHit;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy) else $error("array write outside busy"); // R8

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load || strb.clear) |-> !busy) else $error("buffer touched while busy"); // R11

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && $past(strb.commit)) |->
      (memAddr[ADDR_W-1:PAGE_COL_W] == $past(memAddr[ADDR_W-1:PAGE_COL_W])))
    else $error("page moved during commit"); // R2

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dataByte,
  input  logic [7:0]        dataIn,
  input  logic              srByte,
  input  logic [2:0]        tailBits,
  input  logic              csRise,
  input  logic              wen,
  input  logic              srLocked,
  input  logic [1:0]        protLevel,
  output logic              busy,
  output logic              wenClr,
  output logic              srCommit,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata
);

  bufStrobe_t strb;
  logic       anyByte;

  pgwr_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStart  (wrStart),
    .dataByte (dataByte),
    .srByte   (srByte),
    .tailBits (tailBits),
    .csRise   (csRise),
    .wen      (wen),
    .srLocked (srLocked),
    .anyByte  (anyByte),
    .strb     (strb),
    .busy     (busy),
    .wenClr   (wenClr),
    .srCommit (srCommit)
  );

  pgwr_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .startAddr (startAddr),
    .dataIn    (dataIn),
    .protLevel (protLevel),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .anyByte   (anyByte)
  );

endmodule

// File: tb/sim_pgwr_commit.sv
`timescale 1ns/1ps
module sim_pgwr_commit;

  localparam int AW  = 8;
  localparam int WR  = 40;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrStart = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          dataByte = 1'b0;
  logic [7:0]    dataIn = '0;
  logic          srByte = 1'b0;
  logic [2:0]    tailBits = '0;
  logic          csRise = 1'b0;
  logic          wen = 1'b1;
  logic          srLocked = 1'b0;
  logic [1:0]    protLevel = '0;
  logic          busy, wenClr, srCommit, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata;

  logic [7:0] ram [MEM];
  logic [7:0] expMem [MEM];

  int total = 0;
  int bad = 0;
  int busyCnt = 0, weCnt = 0, clrCnt = 0, clrAt = 0, srcCnt = 0, lateWe = 0;
  logic [15:0] colHits = '0;
  bit dupCol = 0;

  always #2.5 clk = ~clk;

  pgwr_commit #(.ADDR_W(AW), .WR_CYCLES(WR)) u0 (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .startAddr(startAddr),
    .dataByte(dataByte), .dataIn(dataIn), .srByte(srByte), .tailBits(tailBits),
    .csRise(csRise), .wen(wen), .srLocked(srLocked), .protLevel(protLevel),
    .busy(busy), .wenClr(wenClr), .srCommit(srCommit), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM; i++) ram[i] <= 8'(i) ^ 8'h5A;
    end else if (memWe) begin
      ram[memAddr] <= memWdata;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCnt++;
      if (memWe) begin
        weCnt++;
        if (busyCnt > 16) lateWe++;
        if (colHits[memAddr[3:0]]) dupCol = 1;
        colHits[memAddr[3:0]] = 1'b1;
      end
      if (wenClr) begin clrCnt++; clrAt = busyCnt; end
      if (srCommit) srcCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int seed, input int k);
    return 8'(seed * 37 + k * 11 + 3);
  endfunction

  function automatic bit inProt(input int a, input int lvl);
    if (lvl == 3) return 1;
    if (lvl == 2) return a >= MEM / 2;
    if (lvl == 1) return a >= (MEM * 3) / 4;
    return 0;
  endfunction

  task automatic clrMon();
    busyCnt = 0; weCnt = 0; clrCnt = 0; clrAt = 0; srcCnt = 0; lateWe = 0;
    colHits = '0; dupCol = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic sendPage(input int addr, input int len, input int seed);
    wrStart = 1'b1; startAddr = AW'(addr); cyc(); wrStart = 1'b0;
    for (int k = 0; k < len; k++) begin
      dataByte = 1'b1; dataIn = dat(seed, k); cyc();
    end
    dataByte = 1'b0;
  endtask

  task automatic endTxn(input int tail);
    clrMon();
    tailBits = 3'(tail); csRise = 1'b1; cyc(); csRise = 1'b0; tailBits = '0;
  endtask

  task automatic model(input int addr, input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      int a;
      a = (addr & ~15) | ((addr + k) & 15);
      if (!inProt(a, protLevel)) expMem[a] = dat(seed, k);
    end
  endtask

  task automatic checkRam(input string req);
    int badAt;
    badAt = -1;
    for (int i = MEM - 1; i >= 0; i--) if (ram[i] !== expMem[i]) badAt = i;
    if (badAt < 0) check(1, req, 0, 0);
    else check(0, req, ram[badAt], expMem[badAt]);
  endtask

  task automatic expectIdle(input string req);
    repeat (WR + 5) cyc();
    check(busyCnt == 0, req, busyCnt, 0);
    checkRam(req);
  endtask

  initial begin
    for (int i = 0; i < MEM; i++) expMem[i] = 8'(i) ^ 8'h5A;
    repeat (3) cyc();
    // R1 reset state
    check(busy == 0 && memWe == 0 && wenClr == 0 && srCommit == 0, "R1", busy, 0);
    rstN = 1'b1;
    cyc();
    check(busy == 0 && memWe == 0, "R1", memWe, 0);

    // R2 R3 R4 R7 R8 R9: sweep protection, start column, length, page
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int ci = 0; ci < 3; ci++) begin
        for (int li = 0; li < 4; li++) begin
          int col, len, pg, addr, seed, nExp;
          col  = (ci == 0) ? 0 : (ci == 1) ? 3 : 15;
          len  = (li == 0) ? 1 : (li == 1) ? 7 : (li == 2) ? 16 : 19;
          pg   = (lvl * 5 + col + len * 3) % 16;
          addr = pg * 16 + col;
          seed = lvl * 16 + ci * 4 + li;
          protLevel = 2'(lvl);
          sendPage(addr, len, seed);
          endTxn(0);
          repeat (WR + 5) cyc();
          model(addr, len, seed);
          nExp = inProt(addr, lvl) ? 0 : (len > 16 ? 16 : len);
          checkRam("R2");
          check(weCnt == nExp && !dupCol, "R3", weCnt, nExp);
          check(busyCnt == WR && lateWe == 0, "R8", busyCnt, WR);
          check(clrCnt == 1 && clrAt == WR, "R9", clrAt, WR);
        end
      end
    end

    // R7 boundary: level 1 protects from 0xC0, not 0xB0 page
    protLevel = 2'd1;
    sendPage(8'hB8, 16, 90); endTxn(0); repeat (WR + 5) cyc();
    model(8'hB8, 16, 90); checkRam("R7");
    check(weCnt == 16, "R7", weCnt, 16);
    sendPage(8'hC4, 5, 91); endTxn(0); repeat (WR + 5) cyc();
    check(weCnt == 0 && busyCnt == WR, "R7", weCnt, 0);
    checkRam("R7");
    protLevel = 2'd0;

    // R4 partial page: 3 bytes from column 6, other columns untouched
    sendPage(8'h36, 3, 92); endTxn(0); repeat (WR + 5) cyc();
    model(8'h36, 3, 92); checkRam("R4");

    // R5 partial trailing byte discards everything
    sendPage(8'h50, 4, 93); endTxn(3); expectIdle("R5");
    // R6 write enable low
    wen = 1'b0; sendPage(8'h60, 4, 94); endTxn(0); expectIdle("R6"); wen = 1'b1;
    // R6 open write without data
    sendPage(8'h70, 0, 95); endTxn(0); expectIdle("R6");

    // R10 status writes
    srByte = 1'b1; cyc(); srByte = 1'b0; endTxn(0); repeat (WR + 5) cyc();
    check(busyCnt == WR && weCnt == 0, "R10", busyCnt, WR);
    check(srcCnt == 1 && clrCnt == 1, "R10", srcCnt, 1);
    srLocked = 1'b1; srByte = 1'b1; cyc(); srByte = 1'b0; endTxn(0);
    expectIdle("R10"); check(srcCnt == 0, "R10", srcCnt, 0);
    srLocked = 1'b0;
    srByte = 1'b1; cyc(); srByte = 1'b0; endTxn(1); expectIdle("R10");

    // R11 strobes mid-commit and in the final busy clock
    sendPage(8'h24, 10, 96); endTxn(0);
    cyc(); cyc();
    wrStart = 1'b1; startAddr = 8'h90; dataByte = 1'b1; dataIn = 8'hEE; csRise = 1'b1; cyc();
    wrStart = 1'b0; dataByte = 1'b0; csRise = 1'b0;
    while (!wenClr) cyc();
    model(8'h24, 10, 96);
    wrStart = 1'b1; startAddr = 8'hA0; cyc(); wrStart = 1'b0;
    for (int k = 0; k < 3; k++) begin dataByte = 1'b1; dataIn = 8'h11; cyc(); end
    dataByte = 1'b0;
    endTxn(0);
    expectIdle("R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule